// File: doc/BRIEF.md
# Signed Power-of-Two Divider with Truncation Toward Zero

This block divides a signed two's-complement dividend by two raised to an unsigned exponent and delivers the quotient rounded toward zero, the way integer division in most programming languages behaves. It builds the result from a magnitude, a logical right shift and a conditional negation, so no divider circuit is involved. With default parameters the path from inputs to outputs is purely combinational, and the quotient appears in the same cycle as its operands.

A plain arithmetic right shift rounds toward minus infinity, and so gives the wrong answer for negative dividends that are not exact multiples of the divisor. This block avoids that error. It takes the magnitude of a negative dividend, shifts it, and negates it back. The most negative dividend is handled because its magnitude is read as an unsigned value. Exponents above the legal maximum are clamped to that maximum and reported on a flag.

Two build-time switches can add a register in front of the core, a register behind it, or both. Each register adds exactly one cycle of latency, which allows the core to be timed between flops.

Top module: `pow2_trunc_div`

## Requirements
- R1: For exponents 0 to 30, `quot_o` equals the exact quotient of `dividend_i` (signed) by 2 to the power `exp_i`, truncated toward zero.
- R2: A non-negative dividend (bit 31 clear) yields its logical right shift by the exponent: a non-negative result that is never larger than the dividend.
- R3: A negative dividend yields a result that is zero or negative and rounds toward zero, not toward minus infinity. For example, -1 with exponent 1 gives 0, and -3 with exponent 1 gives -1.
- R4: The dividend 0x80000000 (-2^31) is treated as magnitude 2^31. Exponent 0 gives 0x80000000, exponent 1 gives -2^30, and exponent 30 gives -2.
- R5: Exponent 0 returns the dividend unchanged.
- R6: An exponent of 31 is treated as 30, and `exp_clamped_o` is 1. For exponents 0 to 30, `exp_clamped_o` is 0.
- R7: With the default parameters (both registers off), the outputs follow the inputs within the same cycle.
- R8: With `IN_REG` and `OUT_REG` set, the result of an input set appears on `quot_o` and `exp_clamped_o` exactly two rising edges later. While reset is active, both outputs are held at zero.
- R9: A zero dividend gives a zero quotient for every exponent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional stage registers and the checks |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| dividend_i | input | DATA_W (32) | Signed dividend |
| exp_i | input | EXP_W (5) | Unsigned power-of-two exponent |
| quot_o | output | DATA_W (32) | Signed quotient, truncated toward zero |
| exp_clamped_o | output | 1 | High when the exponent was above the maximum and was clamped |

## Verification
Some properties are checked on every cycle. The sign of the quotient must follow the sign of the dividend. A non-negative result must never exceed its dividend. A zero exponent and a zero dividend must each give their fixed result. The effective exponent must stay within its limit and agree with the clamp flag. When the output register is present, it must hold the core result from the cycle before. Other behaviour can only be shown by the bench scenarios, which compare against a 64-bit truncating division. These are the exact rounding values for odd negative dividends, the results for the extreme dividends, the two-edge latency of the registered variant, and the outputs held during reset.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  localparam int unsigned QW    = 32;
  localparam int unsigned EW    = 5;
  localparam int unsigned LIMIT = 30;
endpackage

// File: rtl/pow2_exp_clamp.sv
module pow2_exp_clamp #(
  parameter int unsigned EXP_W   = 5,
  parameter int unsigned MAX_EXP = 30
) (
  input  logic [EXP_W-1:0] exp_raw,
  output logic [EXP_W-1:0] exp_eff,
  output logic             over
);
  localparam logic [EXP_W-1:0] MAX_E = MAX_EXP[EXP_W-1:0];

  always_comb begin
    over    = (exp_raw > MAX_E);
    exp_eff = over ? MAX_E : exp_raw;
  end
endmodule

// File: rtl/pow2_trunc_core.sv
module pow2_trunc_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EXP_W  = 5
) (
  input  logic [DATA_W-1:0] x,
  input  logic [EXP_W-1:0]  sh,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              neg;
  logic [DATA_W-1:0] mag;
  logic [DATA_W-1:0] shr;

  // Magnitude is unsigned, so the most negative value maps to 2^(W-1).
  always_comb begin
    neg = x[DATA_W-1];
    mag = neg ? (~x + ONE) : x;
    shr = mag >> sh;
    q   = neg ? (~shr + ONE) : shr;
  end
endmodule

// File: rtl/pow2_pipe_reg.sv
module pow2_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] d_next;

  always_comb d_next = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d_next;
  end
endmodule

// File: rtl/pow2_trunc_div.sv
module pow2_trunc_div
  import pow2_div_pkg::*;
#(
  parameter int unsigned DATA_W  = QW,
  parameter int unsigned EXP_W   = EW,
  parameter int unsigned MAX_EXP = LIMIT,
  parameter bit          IN_REG  = 1'b0,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [DATA_W-1:0] quot_o,
  output logic              exp_clamped_o
);
  localparam bit          ANY_REG = IN_REG || OUT_REG;
  localparam int unsigned IN_W    = DATA_W + EXP_W;
  localparam int unsigned OUT_W   = DATA_W + 1;
  localparam logic [EXP_W-1:0] MAX_E = MAX_EXP[EXP_W-1:0];

  logic              rst_n_int;
  logic [DATA_W-1:0] x_s;
  logic [EXP_W-1:0]  e_s;
  logic [EXP_W-1:0]  e_eff;
  logic              e_over;
  logic [DATA_W-1:0] core_q;

  // Reset: asserted asynchronously, released on a clock edge.
  generate
    if (ANY_REG) begin : g_rsync
      logic [1:0] sync_q;
      logic [1:0] sync_d;
      always_comb sync_d = {sync_q[0], 1'b1};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
      end
      assign rst_n_int = sync_q[1];
    end else begin : g_rdirect
      assign rst_n_int = rst_n;
    end
  endgenerate

  // Optional input stage
  generate
    if (IN_REG) begin : g_in_reg
      logic [IN_W-1:0] in_q;
      pow2_pipe_reg #(.W(IN_W)) u_in_reg (
        .clk   (clk),
        .rst_n (rst_n_int),
        .en    (1'b1),
        .d     ({dividend_i, exp_i}),
        .q     (in_q)
      );
      assign x_s = in_q[IN_W-1:EXP_W];
      assign e_s = in_q[EXP_W-1:0];
    end else begin : g_in_wire
      assign x_s = dividend_i;
      assign e_s = exp_i;
    end
  endgenerate

  pow2_exp_clamp #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_clamp (
    .exp_raw (e_s),
    .exp_eff (e_eff),
    .over    (e_over)
  );

  pow2_trunc_core #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_core (
    .x  (x_s),
    .sh (e_eff),
    .q  (core_q)
  );

  // Optional output stage
  generate
    if (OUT_REG) begin : g_out_reg
      logic [OUT_W-1:0] out_q;
      pow2_pipe_reg #(.W(OUT_W)) u_out_reg (
        .clk   (clk),
        .rst_n (rst_n_int),
        .en    (1'b1),
        .d     ({core_q, e_over}),
        .q     (out_q)
      );
      assign quot_o        = out_q[OUT_W-1:1];
      assign exp_clamped_o = out_q[0];

      assert_out_stage_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
        $past(rst_n_int) |-> (quot_o == $past(core_q) && exp_clamped_o == $past(e_over)));
    end else begin : g_out_wire
      assign quot_o        = core_q;
      assign exp_clamped_o = e_over;
    end
  endgenerate

  // Clamp checks
  assert_exp_bound_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    e_eff <= MAX_E);
  assert_clamp_value_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    e_over |-> (e_eff == MAX_E));
  assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    !e_over |-> (e_eff == e_s));

  // Core checks
  assert_pos_sign_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    !x_s[DATA_W-1] |-> (!core_q[DATA_W-1] && core_q <= x_s));
  assert_neg_sign_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    x_s[DATA_W-1] |-> (core_q[DATA_W-1] || core_q == '0));
  assert_identity_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (e_eff == '0) |-> (core_q == x_s));
  assert_zero_in_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (x_s == '0) |-> (core_q == '0));
endmodule

// File: tb/pow2_trunc_div_bench.sv
`timescale 1ns/1ps
module pow2_trunc_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] x_in = '0;
  logic [4:0]  e_in = '0;
  logic [31:0] q_c, q_p;
  logic        f_c, f_p;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pow2_trunc_div u_pow2_trunc_div (
    .clk(clk), .rst_n(rst_n), .dividend_i(x_in), .exp_i(e_in),
    .quot_o(q_c), .exp_clamped_o(f_c));

  pow2_trunc_div #(.IN_REG(1'b1), .OUT_REG(1'b1)) u_pow2_trunc_div_piped (
    .clk(clk), .rst_n(rst_n), .dividend_i(x_in), .exp_i(e_in),
    .quot_o(q_p), .exp_clamped_o(f_p));

  function automatic logic [31:0] ref_q(logic [31:0] x, logic [4:0] e);
    longint sx, d, r;
    int ee;
    ee = (e > 5'd30) ? 30 : int'(e);
    sx = longint'($signed(x));
    d  = longint'(1) <<< ee;
    r  = sx / d;
    return r[31:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] x, logic [4:0] e);
    @(negedge clk);
    x_in = x;
    e_in = e;
    #1;
  endtask

  task automatic t_reset();
    x_in = 32'h1234_5678;
    e_in = 5'd3;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset quot", q_p, 32'h0);
    chk("R8 reset flag", {31'b0, f_p}, 32'h0);
  endtask

  task automatic t_positive();
    apply(32'd100, 5'd3);        chk("R2 100>>3", q_c, 32'd12);
    apply(32'h7FFF_FFFF, 5'd30); chk("R2 max>>30", q_c, 32'd1);
    apply(32'h7FFF_FFFF, 5'd1);  chk("R1 max>>1", q_c, 32'h3FFF_FFFF);
    chk("R6 flag low", {31'b0, f_c}, 32'h0);
  endtask

  task automatic t_negative();
    apply(32'hFFFF_FFFF, 5'd1);  chk("R3 -1/2", q_c, 32'h0);
    apply(32'hFFFF_FFFD, 5'd1);  chk("R3 -3/2", q_c, 32'hFFFF_FFFF);
    apply(32'hFFFF_FF9C, 5'd3);  chk("R3 -100/8", q_c, 32'hFFFF_FFF4);
    apply(32'hFFFF_FFFF, 5'd30); chk("R3 -1/2^30", q_c, 32'h0);
    apply(32'hFFFF_FFF8, 5'd3);  chk("R3 -8/8", q_c, 32'hFFFF_FFFF);
  endtask

  task automatic t_extremes();
    apply(32'h8000_0000, 5'd0);  chk("R4 min y0", q_c, 32'h8000_0000);
    apply(32'h8000_0000, 5'd1);  chk("R4 min y1", q_c, 32'hC000_0000);
    apply(32'h8000_0000, 5'd30); chk("R4 min y30", q_c, 32'hFFFF_FFFE);
  endtask

  task automatic t_identity_zero();
    apply(32'hDEAD_BEEF, 5'd0);  chk("R5 identity", q_c, 32'hDEAD_BEEF);
    apply(32'h0, 5'd0);          chk("R9 zero y0", q_c, 32'h0);
    apply(32'h0, 5'd30);         chk("R9 zero y30", q_c, 32'h0);
  endtask

  task automatic t_clamp();
    apply(32'h8000_0000, 5'd31);
    chk("R6 clamp quot", q_c, 32'hFFFF_FFFE);
    chk("R6 clamp flag", {31'b0, f_c}, 32'h1);
    apply(32'h4000_0000, 5'd31);
    chk("R6 clamp pos", q_c, 32'h1);
    apply(32'h4000_0000, 5'd30);
    chk("R6 no flag at 30", {31'b0, f_c}, 32'h0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rx;
      logic [4:0]  re;
      rx = $urandom;
      re = 5'($urandom % 31);
      apply(rx, re);
      chk("R1 random", q_c, ref_q(rx, re));
      chk("R7 same cycle", q_c, ref_q(x_in, e_in));
    end
  endtask

  task automatic t_pipeline();
    apply(32'd64, 5'd2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    x_in = 32'hFFFF_FFF9;
    e_in = 5'd31;
    @(posedge clk); #1;
    chk("R8 one edge old quot", q_p, 32'd16);
    chk("R8 one edge old flag", {31'b0, f_p}, 32'h0);
    @(posedge clk); #1;
    chk("R8 two edges quot", q_p, 32'h0);
    chk("R8 two edges flag", {31'b0, f_p}, 32'h1);
    @(negedge clk);
    x_in = 32'hFFFF_FFF9;
    e_in = 5'd1;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 piped -7/2", q_p, 32'hFFFF_FFFD);
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_positive();
    t_negative();
    t_extremes();
    t_identity_zero();
    t_clamp();
    t_random();
    t_pipeline();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule